// File: doc/BRIEF.md
# Buffer-Window Copy Engine

This block moves bytes between a 4 KiB on-device scratch buffer and host memory. Software sets up four 64-bit registers: source address, destination address, byte count and a command word. Writing the command with its run bit set starts a transfer. The on-device side of a transfer is always an address inside a fixed window (default base 0x40000, 4096 bytes long). The address minus the window base selects the first buffer byte. The host-side address is ANDed with a mask before it leaves the block.

Once started, the engine waits a programmable number of clock cycles and then checks the transfer against the window. If the transfer is legal, it copies one byte at a time. The direction is either host to buffer or buffer to host. When the copy ends, the run bit drops and, if requested, a one-cycle completion pulse fires. A transfer that fails the window check moves no data. It sets a sticky error flag and completes in the same way. All four registers ignore writes while a transfer is in flight.

Host traffic uses byte-wide valid/ready channels. A read request or a write beat, once raised, keeps its address and data stable until ready is sampled high. At most one read is outstanding. The read response has no ready signal: the engine takes `rd_rsp_valid` in any cycle after the request handshake, and the host must assert it only in that situation.

Top module: `sdma_engine`

## Requirements
- R1: Registers sit at offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). An access with `reg_wide`=1 moves 64 bits. With `reg_wide`=0, a write stores the low 32 bits zero-extended and a read returns the low 32 bits zero-extended.
- R2: While the run bit (command bit 0) is set, every register write is ignored. A read of the same register afterwards returns the earlier value.
- R3: A command write whose value has bit 0 clear is ignored. The command register keeps its old value and no transfer starts.
- R4: Command bit 1 selects the direction: 0 copies host to buffer, 1 copies buffer to host. Bit 2 requests a completion pulse. After an accepted start, `busy` is 1 and the command register reads back the written value.
- R5: No host request appears earlier than START_DELAY clock cycles after the command write that starts the transfer.
- R6: In a host-to-buffer copy, the engine reads `count` host bytes at ascending addresses starting at the source. Byte i is stored at buffer offset (destination − base + i).
- R7: In a buffer-to-host copy, the engine writes `count` bytes at ascending host addresses starting at the destination. Byte i carries buffer offset (source − base + i).
- R8: Every host address driven out equals (host base + i) AND HOST_MASK, where HOST_MASK defaults to 2^28−1.
- R9: A transfer is out of range when (device address + count) wraps past 2^64, or when the device address is below the base, or when (device address + count) is above base+4096. An out-of-range transfer issues no host traffic, sets `xfer_err`, and still completes.
- R10: On completion the run bit clears, so `busy` drops and the command reads back with bit 0 clear. `done_irq` pulses for one cycle if and only if command bit 2 was set.
- R11: `xfer_err` stays set until the next accepted start, which clears it.
- R12: A raised `rd_req_valid` or `wr_valid` stays high with stable address and data until the matching ready is high.
- R13: After reset all four registers read 0, and `busy`, `xfer_err`, `done_irq`, `rd_req_valid` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| rd_req_valid | output | 1 | Host read request valid |
| rd_req_ready | input | 1 | Host read request accepted |
| rd_req_addr | output | 64 | Host read byte address |
| rd_rsp_valid | input | 1 | Host read data valid |
| rd_rsp_data | input | 8 | Host read data byte |
| wr_valid | output | 1 | Host write beat valid |
| wr_ready | input | 1 | Host write beat accepted |
| wr_addr | output | 64 | Host write byte address |
| wr_data | output | 8 | Host write data byte |
| busy | output | 1 | Run bit of the command register |
| xfer_err | output | 1 | Sticky out-of-range flag |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hold-until-ready checks assume that the host's ready signals are free to vary, and the bench drives them from periodic patterns that stall both channels. The completion and lock checks rely on software never writing a register and completing a transfer in the same cycle. The engine makes that impossible, because writes are refused while running. The read path assumes the host returns `rd_rsp_valid` only for a request it has accepted. The bench's host model answers exactly one cycle after each read handshake and never at any other time.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CHECK, ST_RDREQ, ST_RDRSP, ST_BUFRD, ST_WR, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wide,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        done_i,
  output logic [63:0] src_o,
  output logic [63:0] dst_o,
  output logic [63:0] cnt_o,
  output logic [2:0]  cmd_o
);
  logic [63:0] src_q, dst_q, cnt_q, cmd_q;
  logic [63:0] wval, rsel;
  logic        locked;

  assign wval   = reg_wide ? reg_wdata : {32'b0, reg_wdata[31:0]};
  assign locked = cmd_q[CMD_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else begin
      if (done_i) cmd_q[CMD_RUN] <= 1'b0;
      if (reg_wr && !locked) begin
        unique case (reg_addr)
          OFS_SRC: src_q <= wval;
          OFS_DST: dst_q <= wval;
          OFS_CNT: cnt_q <= wval;
          OFS_CMD: if (wval[CMD_RUN]) cmd_q <= wval;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_SRC: rsel = src_q;
      OFS_DST: rsel = dst_q;
      OFS_CNT: rsel = cnt_q;
      OFS_CMD: rsel = cmd_q;
      default: rsel = '0;
    endcase
    reg_rdata = reg_wide ? rsel : {32'b0, rsel[31:0]};
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;
  assign cmd_o = cmd_q[2:0];

  // R2
  reg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_wr) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
  // R3
  cmd_norun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && reg_wr && reg_addr == OFS_CMD && !wval[CMD_RUN]) |=> $stable(cmd_q));
endmodule

// File: rtl/sdma_buf.sv
module sdma_buf #(
  parameter int BYTES = 4096,
  localparam int AW    = $clog2(BYTES),
  localparam int WORDS = BYTES / 4
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [31:0] mem [WORDS];
  logic [31:0] word_q;
  logic [1:0]  lane_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr[AW-1:2]][{addr[1:0], 3'b000} +: 8] <= wdata;
    word_q <= mem[addr[AW-1:2]];
    lane_q <= addr[1:0];
  end

  assign rdata = word_q[{lane_q, 3'b000} +: 8];
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter logic [63:0] BUF_BASE    = 64'h40000,
  parameter int          BUF_BYTES   = 4096,
  parameter int          START_DELAY = 16,
  parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int CNT_W = IDX_W + 1,
  localparam int DLY_W = $clog2(START_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      src,
  input  logic [63:0]      dst,
  input  logic [63:0]      cnt,
  input  logic [2:0]       cmd,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [63:0]      rd_req_addr,
  input  logic             rd_rsp_valid,
  input  logic [7:0]       rd_rsp_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [63:0]      wr_addr,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] buf_addr,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata,
  output logic             done,
  output logic             done_irq,
  output logic             err
);
  localparam logic [64:0] WIN_END = {1'b0, BUF_BASE} + 65'(BUF_BYTES);

  seq_state_t       state;
  logic [DLY_W-1:0] dly;
  logic [CNT_W-1:0] pos, cnt_lim;
  logic [63:0]      dev, host, host_addr;
  logic [64:0]      dev_end;
  logic             in_win, last;

  assign dev       = cmd[CMD_DIR] ? src : dst;
  assign host      = cmd[CMD_DIR] ? dst : src;
  assign dev_end   = {1'b0, dev} + {1'b0, cnt};
  assign in_win    = !dev_end[64] && (dev >= BUF_BASE) && (dev_end <= WIN_END);
  assign cnt_lim   = CNT_W'(cnt);
  assign last      = (pos + CNT_W'(1)) == cnt_lim;
  assign host_addr = (host + 64'(pos)) & HOST_MASK;
  assign buf_addr  = IDX_W'(dev - BUF_BASE) + IDX_W'(pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dly   <= '0;
      pos   <= '0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd[CMD_RUN]) begin
          state <= ST_WAIT;
          dly   <= '0;
          pos   <= '0;
          err   <= 1'b0;
        end
        ST_WAIT: begin
          if (dly == DLY_W'(START_DELAY - 1)) state <= ST_CHECK;
          else dly <= dly + DLY_W'(1);
        end
        ST_CHECK: begin
          if (!in_win) begin
            err   <= 1'b1;
            state <= ST_DONE;
          end else if (cnt_lim == '0) state <= ST_DONE;
          else state <= cmd[CMD_DIR] ? ST_BUFRD : ST_RDREQ;
        end
        ST_RDREQ: if (rd_req_ready) state <= ST_RDRSP;
        ST_RDRSP: if (rd_rsp_valid) begin
          if (last) state <= ST_DONE;
          else begin
            pos   <= pos + CNT_W'(1);
            state <= ST_RDREQ;
          end
        end
        ST_BUFRD: state <= ST_WR;
        ST_WR: if (wr_ready) begin
          if (last) state <= ST_DONE;
          else begin
            pos   <= pos + CNT_W'(1);
            state <= ST_BUFRD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == ST_RDREQ);
  assign rd_req_addr  = host_addr;
  assign wr_valid     = (state == ST_WR);
  assign wr_addr      = host_addr;
  assign wr_data      = buf_rdata;
  assign buf_we       = (state == ST_RDRSP) && rd_rsp_valid;
  assign buf_wdata    = rd_rsp_data;
  assign done         = (state == ST_DONE);
  assign done_irq     = done && cmd[CMD_IRQ];

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd[CMD_RUN]);
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_valid) |-> !err);
  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || wr_valid) |-> ((host_addr & ~HOST_MASK) == '0));
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter logic [63:0] BUF_BASE    = 64'h40000,
  parameter int          BUF_BYTES   = 4096,
  parameter int          START_DELAY = 16,
  parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wide,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [63:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [7:0]  rd_rsp_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [63:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        busy,
  output logic        xfer_err,
  output logic        done_irq
);
  localparam int IDX_W = $clog2(BUF_BYTES);

  logic [63:0]      src, dst, cnt;
  logic [2:0]       cmd;
  logic             done;
  logic [IDX_W-1:0] buf_addr;
  logic             buf_we;
  logic [7:0]       buf_wdata, buf_rdata;

  sdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wide(reg_wide), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_i(done), .src_o(src), .dst_o(dst), .cnt_o(cnt), .cmd_o(cmd)
  );

  sdma_seq #(
    .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES),
    .START_DELAY(START_DELAY), .HOST_MASK(HOST_MASK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .src(src), .dst(dst), .cnt(cnt), .cmd(cmd),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .buf_addr(buf_addr),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done(done), .done_irq(done_irq), .err(xfer_err)
  );

  sdma_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .addr(buf_addr), .we(buf_we), .wdata(buf_wdata),
    .rdata(buf_rdata)
  );

  assign busy = cmd[0];
endmodule

// File: tb/sdma_engine_bench.sv
`timescale 1ns/1ps
module sdma_engine_bench;
  localparam int          DELAY = 16;
  localparam logic [63:0] MASK  = 64'h0FFF_FFFF;
  localparam logic [63:0] BASE  = 64'h40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_wide = 1'b1;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        rd_req_valid, rd_req_ready = 1'b0;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [7:0]  rd_rsp_data = 8'h0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [63:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy, xfer_err, done_irq;

  always #4 clk = ~clk;

  sdma_engine #(.START_DELAY(DELAY)) u_sdma_engine (.*);

  int vecs = 0, errs = 0, cyc = 0, irq_cnt = 0, start_cyc = 0;
  bit first_seen = 1'b1, mon_en = 1'b0, rsp_pend = 1'b0, finished = 1'b0;
  logic [63:0] rsp_addr;
  logic [7:0]  bbuf [4096];
  logic [63:0] q_addr[$];
  logic [7:0]  q_data[$];
  int          q_idx[$];
  bit          q_wr[$];

  function automatic logic [7:0] hostbyte(logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // host memory model and per-clock comparison against the expected queue
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      rd_req_ready = (cyc % 3) != 0;
      wr_ready     = (cyc % 4) != 1;
      if (rsp_pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = hostbyte(rsp_addr);
        rsp_pend     = 1'b0;
      end else rd_rsp_valid = 1'b0;
      if ((rd_req_valid || wr_valid) && !first_seen) begin
        first_seen = 1'b1;
        chk((cyc - start_cyc) >= DELAY, "R5 start delay", 64'(cyc - start_cyc), 64'(DELAY));
      end
      if (rd_req_valid && rd_req_ready) begin
        if (q_addr.size() == 0 || q_wr[0]) chk(1'b0, "R9/R6 unexpected read", rd_req_addr, '0);
        else begin
          chk(rd_req_addr == q_addr[0], "R6/R8 read address", rd_req_addr, q_addr[0]);
          bbuf[q_idx[0]] = hostbyte(rd_req_addr);
          void'(q_addr.pop_front()); void'(q_data.pop_front());
          void'(q_idx.pop_front());  void'(q_wr.pop_front());
        end
        rsp_pend = 1'b1;
        rsp_addr = rd_req_addr;
      end
      if (wr_valid && wr_ready) begin
        if (q_addr.size() == 0 || !q_wr[0]) chk(1'b0, "R9/R7 unexpected write", wr_addr, '0);
        else begin
          chk(wr_addr == q_addr[0], "R7/R8 write address", wr_addr, q_addr[0]);
          chk(wr_data == q_data[0], "R7 write data", 64'(wr_data), 64'(q_data[0]));
          void'(q_addr.pop_front()); void'(q_data.pop_front());
          void'(q_idx.pop_front());  void'(q_wr.pop_front());
        end
      end
      if (done_irq) irq_cnt++;
    end
  end

  task automatic wreg(logic [7:0] a, logic [63:0] d, bit wide);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b1;
  endtask

  task automatic rreg(logic [7:0] a, bit wide, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a; reg_wide = wide;
    #1 v = reg_rdata;
    reg_wide = 1'b1;
  endtask

  task automatic expect_in(logic [63:0] host, int idx, int n);
    for (int i = 0; i < n; i++) begin
      q_addr.push_back((host + 64'(i)) & MASK); q_data.push_back(8'h0);
      q_idx.push_back(idx + i); q_wr.push_back(1'b0);
    end
  endtask

  task automatic expect_out(logic [63:0] host, int idx, int n);
    for (int i = 0; i < n; i++) begin
      q_addr.push_back((host + 64'(i)) & MASK); q_data.push_back(bbuf[idx + i]);
      q_idx.push_back(idx + i); q_wr.push_back(1'b1);
    end
  endtask

  task automatic run(logic [63:0] s, logic [63:0] d, logic [63:0] n, logic [63:0] c);
    wreg(8'h80, s, 1'b1);
    wreg(8'h88, d, 1'b1);
    wreg(8'h90, n, 1'b1);
    irq_cnt = 0;
    start_cyc = cyc; first_seen = 1'b0;
    wreg(8'h98, c, 1'b1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; vecs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R13 reset state
    for (int a = 0; a < 4; a++) begin
      rreg(8'h80 + 8'(a * 8), 1'b1, v);
      chk(v == 0, "R13 register reset", v, 0);
    end
    chk({busy, xfer_err, done_irq, rd_req_valid, wr_valid} == 0, "R13 outputs reset",
        64'({busy, xfer_err, done_irq, rd_req_valid, wr_valid}), 0);

    // R1 access widths
    wreg(8'h80, 64'h1234_5678_9ABC_DEF0, 1'b1);
    rreg(8'h80, 1'b1, v); chk(v == 64'h1234_5678_9ABC_DEF0, "R1 wide readback", v, 64'h1234_5678_9ABC_DEF0);
    rreg(8'h80, 1'b0, v); chk(v == 64'h9ABC_DEF0, "R1 narrow read", v, 64'h9ABC_DEF0);
    wreg(8'h80, 64'hFFFF_FFFF_1111_2222, 1'b0);
    rreg(8'h80, 1'b1, v); chk(v == 64'h1111_2222, "R1 narrow write zero-extends", v, 64'h1111_2222);

    // R3 command without run ignored
    wreg(8'h98, 64'h6, 1'b1);
    rreg(8'h98, 1'b1, v); chk(v == 0, "R3 command without run", v, 0);
    chk(busy == 1'b0, "R3 no start", 64'(busy), 0);

    // R6 R8 inbound with masked host address, irq requested
    expect_in(64'hF000_0100, 16, 8);
    run(64'hF000_0100, BASE + 64'h10, 8, 64'h5);
    rreg(8'h98, 1'b1, v); chk(v == 64'h5, "R4 command readback", v, 64'h5);
    chk(busy == 1'b1, "R4 busy after start", 64'(busy), 1);
    wreg(8'h80, 64'h0, 1'b1);
    wreg(8'h90, 64'h3, 1'b1);
    rreg(8'h80, 1'b1, v); chk(v == 64'hF000_0100, "R2 source locked", v, 64'hF000_0100);
    rreg(8'h90, 1'b1, v); chk(v == 64'h8, "R2 count locked", v, 64'h8);
    wait_idle();
    rreg(8'h98, 1'b1, v); chk(v == 64'h4, "R10 run cleared", v, 64'h4);
    chk(irq_cnt == 1, "R10 irq pulse", 64'(irq_cnt), 1);
    chk(q_addr.size() == 0, "R6 all bytes read", 64'(q_addr.size()), 0);
    chk(xfer_err == 1'b0, "R9 legal no error", 64'(xfer_err), 0);

    // R7 outbound, no irq
    expect_out(64'h300, 16, 8);
    run(BASE + 64'h10, 64'h300, 8, 64'h3);
    wait_idle();
    chk(irq_cnt == 0, "R10 no irq without bit2", 64'(irq_cnt), 0);
    chk(q_addr.size() == 0, "R7 all bytes written", 64'(q_addr.size()), 0);

    // R9 window edges accepted
    expect_in(64'h500, 4092, 4);
    run(64'h500, BASE + 64'hFFC, 4, 64'h1); wait_idle();
    expect_out(64'h600, 4092, 4);
    run(BASE + 64'hFFC, 64'h600, 4, 64'h3); wait_idle();
    expect_in(64'h700, 0, 2);
    run(64'h700, BASE, 2, 64'h1); wait_idle();
    expect_out(64'h800, 0, 2);
    run(BASE, 64'h800, 2, 64'h3); wait_idle();
    chk(q_addr.size() == 0 && xfer_err == 1'b0, "R9 edge transfers", 64'(q_addr.size()), 0);

    // R9 past end of window
    run(64'h900, BASE + 64'hFFE, 4, 64'h5); wait_idle();
    chk(xfer_err == 1'b1, "R9 past end error", 64'(xfer_err), 1);
    chk(irq_cnt == 1, "R9 error still completes", 64'(irq_cnt), 1);
    rreg(8'h98, 1'b1, v); chk(v == 64'h4, "R10 run cleared on error", v, 64'h4);
    repeat (20) @(negedge clk);
    chk(xfer_err == 1'b1, "R11 error sticky", 64'(xfer_err), 1);

    // R9 below base
    run(64'h900, BASE - 1, 1, 64'h1); wait_idle();
    chk(xfer_err == 1'b1, "R9 below base error", 64'(xfer_err), 1);

    // R11 cleared by next accepted start (zero-length legal transfer)
    run(64'h900, BASE, 0, 64'h1); wait_idle();
    chk(xfer_err == 1'b0, "R11 error cleared by start", 64'(xfer_err), 0);

    // R9 wrapping end
    run(64'hFFFF_FFFF_FFFF_FFF8, 64'hA00, 64'h10, 64'h3); wait_idle();
    chk(xfer_err == 1'b1, "R9 wrap error", 64'(xfer_err), 1);
    chk(q_addr.size() == 0, "R9 no traffic", 64'(q_addr.size()), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule